// File: doc/BRIEF.md
# Two-Level Error Severity Aggregator

This block gathers single-cycle error pulses from two groups of internal sources: correctable and uncorrectable. Every pulse leaves a sticky bit in a local status register. Each source has a mask bit. Each uncorrectable source also has a severity bit that sends it to either the fatal class or the non-fatal class. Unmasked errors therefore fall into three global classes: correctable, non-fatal and fatal.

Both levels keep a first-error record and a next-error record. The local level keeps one pair per group. The global level keeps one pair per class. Each record stores the index of the source that caused it.

Each global class that is set and not masked drives three kinds of output. A programmable event map routes it to NMI and SMI request outputs. It also drives its own active-low error pin. Software reaches all state through a synchronous read/write register port. The status bits and the record valid flags are cleared by writing one to them.

Top module: `err_sev_agg`

## Requirements
- R1: A pulse on `cor_err_i[i]` or `unc_err_i[i]` sets local status bit i at the next edge, whether or not the source is masked. Writing 1 to a status bit clears it. If a new error arrives in the same cycle as the clear, the error wins and the bit stays set.
- R2: A source whose local mask bit is 1 sets only its local status bit. It reaches no log, no global status bit and no output.
- R3: The global status bits are fixed by position: bit 0 is correctable, bit 1 is non-fatal, bit 2 is fatal. An unmasked correctable error sets bit 0. An unmasked uncorrectable error sets bit 2 if its severity bit is 1 and bit 1 if its severity bit is 0. These bits are cleared by writing 1.
- R4: Each log word has the same layout: bit 0 is first-valid, bit 1 is next-valid, and bits 15:8 hold the first-error source index. While first-valid is clear, an unmasked error captures the lowest index present and sets first-valid. If more than one error arrives in that cycle, next-valid is set as well. While first-valid is set, any further error sets only next-valid, and the index is held.
- R5: Writing 1 to first-valid clears both valid flags. Writing 1 to next-valid clears only next-valid. The index field keeps its last value. An error that arrives in the same cycle as a first-valid clear is captured as a new first error.
- R6: Each global class has its own log, in the R4 layout. It holds the index of the local source that caused the event. It records an event only if the class is unmasked in the global mask.
- R7: A class whose global mask bit is 1 still sets its global status bit. It drives no log entry, no pin and no NMI or SMI.
- R8: The event map gives two bits per class. Bit 2c requests NMI and bit 2c+1 requests SMI, for class c in the order correctable, non-fatal, fatal. `nmi_o` and `smi_o` are the OR over the active classes, registered one cycle after the global status.
- R9: `err_n_o[c]` is low from the cycle after class c becomes active (set and unmasked). It returns high one cycle after the class stops being active.
- R10: The register map is:

  | Address | Register |
  |---|---|
  | 0 | correctable status |
  | 1 | correctable mask |
  | 2 | uncorrectable status |
  | 3 | uncorrectable mask |
  | 4 | severity (1 = fatal) |
  | 5 | correctable log |
  | 6 | uncorrectable log |
  | 7 | global status |
  | 8 | global mask |
  | 9 to 11 | global logs for correctable, non-fatal and fatal |
  | 12 | event map |

  Read data is registered: `rdata_o` shows the word at `addr_i` one cycle after the address is presented. Masks, severity and the event map reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cor_err_i | input | N_COR | Correctable error pulses |
| unc_err_i | input | N_UNC | Uncorrectable error pulses |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| nmi_o | output | 1 | NMI request |
| smi_o | output | 1 | SMI request |
| err_n_o | output | 3 | Active-low class pins (correctable, non-fatal, fatal) |

## Verification
An error can arrive in the same cycle that software clears the bit or record it would set. The bench provokes this by issuing a write-one-to-clear on a status register, and separately on a first-valid flag, in the same cycle that it pulses a matching source. It then reads the word back and expects the status bit to remain set and the log to hold the newly captured index. A second collision is a simultaneous pulse on two sources into an empty log. This must yield the lower index and a set next-valid flag.

// File: rtl/err_sev_pkg.sv
package err_sev_pkg;

    localparam int DW   = 16;
    localparam int AW   = 4;
    localparam int NCLS = 3;

    typedef enum logic [1:0] {
        CLS_COR = 2'd0,
        CLS_NF  = 2'd1,
        CLS_FAT = 2'd2
    } err_cls_e;

    localparam logic [AW-1:0] A_COR_STS = 4'd0;
    localparam logic [AW-1:0] A_COR_MSK = 4'd1;
    localparam logic [AW-1:0] A_UNC_STS = 4'd2;
    localparam logic [AW-1:0] A_UNC_MSK = 4'd3;
    localparam logic [AW-1:0] A_UNC_SEV = 4'd4;
    localparam logic [AW-1:0] A_COR_LOG = 4'd5;
    localparam logic [AW-1:0] A_UNC_LOG = 4'd6;
    localparam logic [AW-1:0] A_G_STS   = 4'd7;
    localparam logic [AW-1:0] A_G_MSK   = 4'd8;
    localparam logic [AW-1:0] A_G_LOG0  = 4'd9;
    localparam logic [AW-1:0] A_EVMAP   = 4'd12;

    typedef struct packed {
        logic [7:0] idx;
        logic       nv;
        logic       fv;
    } flog_t;

    function automatic logic [DW-1:0] flog_word(flog_t l);
        return {l.idx, 6'b0, l.nv, l.fv};
    endfunction

endpackage

// File: rtl/err_fn_log.sv
module err_fn_log
    import err_sev_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev_i,
    input  logic         clr_first_i,
    input  logic         clr_next_i,
    output flog_t        log_o
);

    flog_t      q, d;
    logic [7:0] low_idx;
    logic       multi;

    always_comb begin
        low_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (ev_i[k]) low_idx = 8'(k);
        end
    end

    assign multi = |(ev_i & (ev_i - N'(1)));

    always_comb begin
        d    = q;
        d.fv = q.fv & ~clr_first_i;
        d.nv = q.nv & ~clr_first_i & ~clr_next_i;
        if (|ev_i) begin
            if (!d.fv) begin
                d.fv  = 1'b1;
                d.idx = low_idx;
                d.nv  = d.nv | multi;
            end else begin
                d.nv  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign log_o = q;

endmodule

// File: rtl/err_evt_route.sv
module err_evt_route
    import err_sev_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCLS-1:0]      act_i,
    input  logic [2*NCLS-1:0]    map_i,
    output logic                 nmi_o,
    output logic                 smi_o,
    output logic [NCLS-1:0]      err_n_o
);

    logic [NCLS-1:0] nmi_sel, smi_sel;

    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_cls
            assign nmi_sel[c] = act_i[c] & map_i[2*c];
            assign smi_sel[c] = act_i[c] & map_i[2*c+1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_o   <= 1'b0;
            smi_o   <= 1'b0;
            err_n_o <= '1;
        end else begin
            nmi_o   <= |nmi_sel;
            smi_o   <= |smi_sel;
            err_n_o <= ~act_i;
        end
    end

endmodule

// File: rtl/err_sev_agg.sv
module err_sev_agg
    import err_sev_pkg::*;
#(
    parameter int N_COR = 4,
    parameter int N_UNC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_COR-1:0] cor_err_i,
    input  logic [N_UNC-1:0] unc_err_i,
    input  logic             wr_en_i,
    input  logic [3:0]       addr_i,
    input  logic [15:0]      wdata_i,
    output logic [15:0]      rdata_o,
    output logic             nmi_o,
    output logic             smi_o,
    output logic [2:0]       err_n_o
);

    localparam int NMAX = (N_COR > N_UNC) ? N_COR : N_UNC;

    logic [N_COR-1:0]     cor_sts_q, cor_msk_q, cor_ev;
    logic [N_UNC-1:0]     unc_sts_q, unc_msk_q, unc_sev_q, unc_ev;
    logic [NCLS-1:0]      gsts_q, gmsk_q, cls_hit, act;
    logic [2*NCLS-1:0]    map_q;
    logic [NMAX-1:0]      gev [NCLS];
    flog_t                cor_log, unc_log;
    flog_t                glog [NCLS];

    function automatic logic wsel(logic [3:0] a);
        return wr_en_i && (addr_i == a);
    endfunction

    // Local event qualification and class split
    assign cor_ev = cor_err_i & ~cor_msk_q;
    assign unc_ev = unc_err_i & ~unc_msk_q;

    assign cls_hit[CLS_COR] = |cor_ev;
    assign cls_hit[CLS_NF]  = |(unc_ev & ~unc_sev_q);
    assign cls_hit[CLS_FAT] = |(unc_ev & unc_sev_q);

    assign gev[CLS_COR] = NMAX'(cor_ev)              & {NMAX{~gmsk_q[CLS_COR]}};
    assign gev[CLS_NF]  = NMAX'(unc_ev & ~unc_sev_q) & {NMAX{~gmsk_q[CLS_NF]}};
    assign gev[CLS_FAT] = NMAX'(unc_ev & unc_sev_q)  & {NMAX{~gmsk_q[CLS_FAT]}};

    assign act = gsts_q & ~gmsk_q;

    // Status, mask, severity and map registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cor_sts_q <= '0;
            cor_msk_q <= '0;
            unc_sts_q <= '0;
            unc_msk_q <= '0;
            unc_sev_q <= '0;
            gsts_q    <= '0;
            gmsk_q    <= '0;
            map_q     <= '0;
        end else begin
            cor_sts_q <= (cor_sts_q & ~(wsel(A_COR_STS) ? wdata_i[N_COR-1:0] : '0)) | cor_err_i;
            unc_sts_q <= (unc_sts_q & ~(wsel(A_UNC_STS) ? wdata_i[N_UNC-1:0] : '0)) | unc_err_i;
            gsts_q    <= (gsts_q & ~(wsel(A_G_STS) ? wdata_i[NCLS-1:0] : '0)) | cls_hit;
            if (wsel(A_COR_MSK)) cor_msk_q <= wdata_i[N_COR-1:0];
            if (wsel(A_UNC_MSK)) unc_msk_q <= wdata_i[N_UNC-1:0];
            if (wsel(A_UNC_SEV)) unc_sev_q <= wdata_i[N_UNC-1:0];
            if (wsel(A_G_MSK))   gmsk_q    <= wdata_i[NCLS-1:0];
            if (wsel(A_EVMAP))   map_q     <= wdata_i[2*NCLS-1:0];
        end
    end

    // Local first/next logs
    err_fn_log #(.N(N_COR)) u_cor_log (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (cor_ev),
        .clr_first_i (wsel(A_COR_LOG) && wdata_i[0]),
        .clr_next_i  (wsel(A_COR_LOG) && wdata_i[1]),
        .log_o       (cor_log)
    );

    err_fn_log #(.N(N_UNC)) u_unc_log (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (unc_ev),
        .clr_first_i (wsel(A_UNC_LOG) && wdata_i[0]),
        .clr_next_i  (wsel(A_UNC_LOG) && wdata_i[1]),
        .log_o       (unc_log)
    );

    // Global per-class first/next logs
    generate
        for (genvar c = 0; c < NCLS; c++) begin : g_glog
            localparam logic [3:0] LA = A_G_LOG0 + 4'(c);
            err_fn_log #(.N(NMAX)) u_glog (
                .clk         (clk),
                .rst         (rst),
                .ev_i        (gev[c]),
                .clr_first_i (wsel(LA) && wdata_i[0]),
                .clr_next_i  (wsel(LA) && wdata_i[1]),
                .log_o       (glog[c])
            );
        end
    endgenerate

    // Event map and output pins
    err_evt_route u_route (
        .clk     (clk),
        .rst     (rst),
        .act_i   (act),
        .map_i   (map_q),
        .nmi_o   (nmi_o),
        .smi_o   (smi_o),
        .err_n_o (err_n_o)
    );

    // Registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else begin
            unique case (addr_i)
                A_COR_STS: rdata_o <= 16'(cor_sts_q);
                A_COR_MSK: rdata_o <= 16'(cor_msk_q);
                A_UNC_STS: rdata_o <= 16'(unc_sts_q);
                A_UNC_MSK: rdata_o <= 16'(unc_msk_q);
                A_UNC_SEV: rdata_o <= 16'(unc_sev_q);
                A_COR_LOG: rdata_o <= flog_word(cor_log);
                A_UNC_LOG: rdata_o <= flog_word(unc_log);
                A_G_STS:   rdata_o <= 16'(gsts_q);
                A_G_MSK:   rdata_o <= 16'(gmsk_q);
                4'd9:      rdata_o <= flog_word(glog[0]);
                4'd10:     rdata_o <= flog_word(glog[1]);
                4'd11:     rdata_o <= flog_word(glog[2]);
                A_EVMAP:   rdata_o <= 16'(map_q);
                default:   rdata_o <= '0;
            endcase
        end
    end

endmodule

// File: rtl/err_sev_agg_chk.sv
module err_sev_agg_chk
    import err_sev_pkg::*;
#(
    parameter int N_COR = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_COR-1:0] cor_err_i,
    input logic [N_COR-1:0] cor_msk_q,
    input logic [N_COR-1:0] cor_sts_q,
    input logic [2:0]       gsts_q,
    input logic [2:0]       gmsk_q,
    input logic [2:0]       err_n_o,
    input logic             nmi_o,
    input logic             smi_o,
    input logic             wr_en_i,
    input logic [3:0]       addr_i,
    input logic [15:0]      wdata_i,
    input flog_t            cor_log
);

    // R1: a pulse always lands in local status
    a_r1_local_set: assert property (@(posedge clk) disable iff (rst)
        (cor_err_i != '0) |=> ((cor_sts_q & $past(cor_err_i)) == $past(cor_err_i)));

    // R2: fully masked correctable pulses leave the global class clear
    a_r2_masked_blocked: assert property (@(posedge clk) disable iff (rst)
        (((cor_err_i & ~cor_msk_q) == '0) && !gsts_q[0]) |=> !gsts_q[0]);

    // R4: a valid first record holds its index until cleared
    a_r4_first_held: assert property (@(posedge clk) disable iff (rst)
        (cor_log.fv && !(wr_en_i && addr_i == A_COR_LOG && wdata_i[0]))
        |=> (cor_log.fv && cor_log.idx == $past(cor_log.idx)));

    // R8: no active class means no NMI/SMI request on the next cycle
    a_r8_quiet_requests: assert property (@(posedge clk) disable iff (rst)
        ((gsts_q & ~gmsk_q) == 3'b000) |=> (!nmi_o && !smi_o));

    // R9: pins follow the active classes one cycle later
    a_r9_pin_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err_n_o == ~$past(gsts_q & ~gmsk_q)));

endmodule

bind err_sev_agg err_sev_agg_chk #(.N_COR(N_COR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cor_err_i (cor_err_i),
    .cor_msk_q (cor_msk_q),
    .cor_sts_q (cor_sts_q),
    .gsts_q    (gsts_q),
    .gmsk_q    (gmsk_q),
    .err_n_o   (err_n_o),
    .nmi_o     (nmi_o),
    .smi_o     (smi_o),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cor_log   (cor_log)
);

// File: tb/err_sev_agg_bench.sv
module err_sev_agg_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cor_err = '0;
    logic [3:0]  unc_err = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        nmi, smi;
    logic [2:0]  err_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    err_sev_agg u_err_sev_agg (
        .clk(clk), .rst(rst), .cor_err_i(cor_err), .unc_err_i(unc_err),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .nmi_o(nmi), .smi_o(smi), .err_n_o(err_n)
    );

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        addr = a;
        step();
        d = rdata;
    endtask

    task automatic pulse(logic [3:0] c, logic [3:0] u);
        cor_err = c; unc_err = u;
        step();
        cor_err = '0; unc_err = '0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        chk("R9 reset pins", {13'b0, err_n}, 16'h0007);
        chk("R8 reset nmi/smi", {14'b0, nmi, smi}, 16'h0000);
        rd_chk("R10 reset gsts", 4'd7, 16'h0000);
        rd_chk("R10 reset cor log", 4'd5, 16'h0000);
        rd_chk("R10 reset map", 4'd12, 16'h0000);
    endtask

    task automatic t_local_first_next();
        pulse(4'b0100, 4'b0000);
        chk("R9 pin not yet low", {13'b0, err_n}, 16'h0007);
        step();
        chk("R9 cor pin low", {13'b0, err_n}, 16'h0006);
        rd_chk("R1 cor status", 4'd0, 16'h0004);
        rd_chk("R4 first capture", 4'd5, 16'h0201);
        rd_chk("R3 cor class", 4'd7, 16'h0001);
        rd_chk("R6 global cor log", 4'd9, 16'h0201);
        pulse(4'b0001, 4'b0000);
        rd_chk("R4 next set, idx held", 4'd5, 16'h0203);
        rd_chk("R1 accumulate", 4'd0, 16'h0005);
    endtask

    task automatic t_clear();
        wr(4'd5, 16'h0002);
        rd_chk("R5 next-only clear", 4'd5, 16'h0201);
        wr(4'd5, 16'h0001);
        rd_chk("R5 first clear drops both", 4'd5, 16'h0200);
        wr(4'd0, 16'h0005);
        rd_chk("R1 w1c", 4'd0, 16'h0000);
        wr(4'd9, 16'h0001);
        wr(4'd7, 16'h0001);
        chk("R9 pin held on clear edge", {13'b0, err_n}, 16'h0006);
        step();
        chk("R9 pin released next cycle", {13'b0, err_n}, 16'h0007);
    endtask

    task automatic t_tie();
        pulse(4'b1010, 4'b0000);
        rd_chk("R4 tie lowest idx + next", 4'd5, 16'h0103);
        wr(4'd5, 16'h0001);
        wr(4'd0, 16'h000F);
        wr(4'd9, 16'h0001);
        wr(4'd7, 16'h0007);
        step();
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(4'd1, 16'h0001);
        pulse(4'b0001, 4'b0000);
        step();
        rd_chk("R1 masked still sets local", 4'd0, 16'h0001);
        rd(4'd5, v);
        chk("R2 masked not logged", {14'b0, v[1:0]}, 16'h0000);
        rd_chk("R2 masked no global", 4'd7, 16'h0000);
        chk("R2 masked no pin", {13'b0, err_n}, 16'h0007);
        wr(4'd1, 16'h0000);
        wr(4'd0, 16'h000F);
    endtask

    task automatic t_severity();
        wr(4'd4, 16'h0002);
        pulse(4'b0000, 4'b0010);
        rd_chk("R3 sev=1 fatal", 4'd7, 16'h0004);
        pulse(4'b0000, 4'b0001);
        rd_chk("R3 sev=0 non-fatal", 4'd7, 16'h0006);
        rd_chk("R4 unc log", 4'd6, 16'h0103);
        rd_chk("R6 fatal log", 4'd11, 16'h0101);
        rd_chk("R6 non-fatal log", 4'd10, 16'h0001);
        chk("R9 nf+fatal pins", {13'b0, err_n}, 16'h0001);
    endtask

    task automatic t_evmap();
        logic [15:0] v;
        wr(4'd12, 16'h0009);
        step();
        chk("R8 smi from nf only", {14'b0, nmi, smi}, 16'h0001);
        wr(4'd8, 16'h0002);
        step();
        chk("R7 masked class drops smi", {14'b0, nmi, smi}, 16'h0000);
        chk("R7 masked class pin high", {13'b0, err_n}, 16'h0003);
        rd_chk("R7 status kept", 4'd7, 16'h0006);
        wr(4'd10, 16'h0001);
        pulse(4'b0000, 4'b0001);
        rd(4'd10, v);
        chk("R7 masked class not logged", {15'b0, v[0]}, 16'h0000);
        wr(4'd8, 16'h0000);
        wr(4'd7, 16'h0007);
        wr(4'd12, 16'h0001);
        pulse(4'b0001, 4'b0000);
        step();
        chk("R8 nmi from cor", {14'b0, nmi, smi}, 16'h0002);
        wr(4'd7, 16'h0007);
        step();
        chk("R8 nmi released", {14'b0, nmi, smi}, 16'h0000);
    endtask

    task automatic t_collision();
        wr(4'd0, 16'h000F);
        wr(4'd5, 16'h0003);
        pulse(4'b0001, 4'b0000);
        cor_err = 4'b1000;
        wr_en = 1'b1; addr = 4'd5; wdata = 16'h0003;
        step();
        cor_err = '0; wr_en = 1'b0;
        rd_chk("R5 capture beats clear", 4'd5, 16'h0301);
        cor_err = 4'b0100;
        wr_en = 1'b1; addr = 4'd0; wdata = 16'h000F;
        step();
        cor_err = '0; wr_en = 1'b0;
        rd_chk("R1 set beats w1c", 4'd0, 16'h0004);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_local_first_next();
        t_clear();
        t_tie();
        t_mask();
        t_severity();
        t_evmap();
        t_collision();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule